// File: doc/BRIEF.md
# Accumulator ALU with Buffered Memory Operand

This block is the arithmetic heart of a single-address machine: a 16-bit accumulator, a 16-bit operand buffer and the combinational logic between them. A word read from memory is captured into the buffer when `opnd_load` is high at a clock edge. In a later cycle, a one-hot operation select chooses how the accumulator is rewritten from its old value and the buffered operand.

Some operations combine the accumulator with the operand: add, subtract, multiply, AND and OR. Others ignore the old accumulator and write a transformed operand into it: load, complement, and the one-bit shifts in either direction. The accumulator is always visible on `acc_out`, which is the data a store writes to memory. Its top bit is repeated on `acc_neg` for conditional branches.

Memory, instruction decode and sequencing sit outside the block. The interface is plain control: there is no handshake, because each select line is a strobe from the sequencer that is acted on in the cycle it is present.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_n` is low, the accumulator and the operand buffer are zero, so `acc_out` reads 0 and `acc_neg` reads 0.
- R2: A clock edge with `opnd_load` high captures `opnd_in` into the operand buffer. Without `opnd_load` the buffer holds its value. An operation strobed at the same edge as a capture uses the previous buffer contents.
- R3: Select bit 0 (load) copies the operand buffer into the accumulator. `acc_out` continuously presents the accumulator as store data.
- R4: Select bit 1 (add) writes accumulator plus operand, and select bit 2 (subtract) writes accumulator minus operand. Both wrap modulo 2^16 with no carry or overflow output.
- R5: Select bit 3 (multiply) writes the low 16 bits of the product of accumulator and operand.
- R6: Select bit 4 writes accumulator AND operand, and select bit 5 writes accumulator OR operand.
- R7: Select bit 6 writes the bitwise complement of the operand, not of the accumulator.
- R8: Select bit 7 writes the operand shifted right by one with a zero entering bit 15. Select bit 8 writes the operand shifted left by one with a zero entering bit 0.
- R9: The accumulator changes only at a clock edge where exactly one of the nine select bits is high. An all-zero select, or one with two or more bits high, leaves it unchanged. A new value appears on `acc_out` right after the edge that applies it.
- R10: `acc_neg` equals bit 15 of `acc_out` at all times; the accumulator counts as non-negative when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_load | input | 1 | Capture `opnd_in` into the operand buffer |
| opnd_in | input | 16 | Word from the memory data register |
| op_sel | input | 9 | One-hot operation select (bit meanings in R3 to R8) |
| acc_out | output | 16 | Accumulator value, used as store data |
| acc_neg | output | 1 | Sign of the accumulator (bit 15) |

## Verification
The buffer capture and every accumulator update take exactly one clock edge. A strobe applied before edge k is visible on `acc_out` from just after edge k, and `acc_neg` follows with no further delay. The bench drives its inputs on the falling edge and advances a behavioural model at the same rising edges as the design. It compares both outputs on the next falling edge, so each comparison sees the result of exactly one edge. Same-edge capture-and-use, multi-bit and empty selects, and wrapping values are placed where that one-edge timing makes the expected value unambiguous.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_N = 9;
  localparam int OP_IDX_W = 4;

  typedef enum logic [OP_IDX_W-1:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_INV  = 4'd6,
    OP_SHR  = 4'd7,
    OP_SHL  = 4'd8
  } acc_op_e;

endpackage

// File: rtl/acc_operand_reg.sv
module acc_operand_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_alu_pkg::*;
(
  input  logic [OP_N-1:0] op_sel,
  output logic            single,
  output acc_op_e         op
);

  assign single = $onehot(op_sel);

  // Index of the highest set bit; only meaningful when single is high.
  always_comb begin
    op = OP_LOAD;
    for (int i = 0; i < OP_N; i++) begin
      if (op_sel[i]) op = acc_op_e'(OP_IDX_W'(i));
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  acc_op_e      op,
  output logic [W-1:0] result
);

  logic [W-1:0] sum_r, dif_r, mul_r, shr_r, shl_r;

  assign sum_r = acc + opnd;
  assign dif_r = acc - opnd;
  assign mul_r = acc * opnd;            // self-determined width keeps the low W bits
  assign shr_r = {1'b0, opnd[W-1:1]};
  assign shl_r = {opnd[W-2:0], 1'b0};

  always_comb begin
    unique case (op)
      OP_LOAD: result = opnd;
      OP_ADD:  result = sum_r;
      OP_SUB:  result = dif_r;
      OP_MUL:  result = mul_r;
      OP_AND:  result = acc & opnd;
      OP_OR:   result = acc | opnd;
      OP_INV:  result = ~opnd;
      OP_SHR:  result = shr_r;
      OP_SHL:  result = shl_r;
      default: result = acc;
    endcase
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opnd_load,
  input  logic [W-1:0]    opnd_in,
  input  logic [OP_N-1:0] op_sel,
  output logic [W-1:0]    acc_out,
  output logic            acc_neg
);

  logic [W-1:0] br_q;
  logic [W-1:0] alu_res;
  logic [W-1:0] acc_q;
  logic         op_single;
  acc_op_e      op_idx;

  acc_operand_reg #(.W(W)) u_br (
    .clk  (clk),
    .rst_n(rst_n),
    .load (opnd_load),
    .d    (opnd_in),
    .q    (br_q)
  );

  acc_op_decode u_dec (
    .op_sel(op_sel),
    .single(op_single),
    .op    (op_idx)
  );

  acc_alu_core #(.W(W)) u_core (
    .acc   (acc_q),
    .opnd  (br_q),
    .op    (op_idx),
    .result(alu_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (op_single) acc_q <= alu_res;
  end

  assign acc_out = acc_q;
  assign acc_neg = acc_q[W-1];

endmodule

// File: rtl/acc_alu_unit_chk.sv
module acc_alu_unit_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            opnd_load,
  input logic [W-1:0]    opnd_in,
  input logic [OP_N-1:0] op_sel,
  input logic [W-1:0]    br_q,
  input logic [W-1:0]    acc_out
);

  localparam logic [OP_N-1:0] S_LOAD = OP_N'(1) << OP_LOAD;
  localparam logic [OP_N-1:0] S_ADD  = OP_N'(1) << OP_ADD;
  localparam logic [OP_N-1:0] S_SUB  = OP_N'(1) << OP_SUB;
  localparam logic [OP_N-1:0] S_INV  = OP_N'(1) << OP_INV;
  localparam logic [OP_N-1:0] S_SHR  = OP_N'(1) << OP_SHR;
  localparam logic [OP_N-1:0] S_SHL  = OP_N'(1) << OP_SHL;

  AST_BR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_load |=> br_q == $past(opnd_in)); // R2
  AST_BR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !opnd_load |=> $stable(br_q)); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_LOAD |=> acc_out == $past(br_q)); // R3
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_ADD |=> acc_out == W'($past(acc_out) + $past(br_q))); // R4
  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_SUB |=> acc_out == W'($past(acc_out) - $past(br_q))); // R4
  AST_INV_OPND: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_INV |=> acc_out == ~$past(br_q)); // R7
  AST_SHR_ZERO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_SHR |=> !acc_out[W-1]); // R8
  AST_SHL_ZERO_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == S_SHL |=> !acc_out[0]); // R8
  AST_HOLD_NOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(op_sel) |=> $stable(acc_out)); // R9

endmodule

bind acc_alu_unit acc_alu_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opnd_load(opnd_load),
  .opnd_in  (opnd_in),
  .op_sel   (op_sel),
  .br_q     (br_q),
  .acc_out  (acc_out)
);

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSEL = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            opnd_load = 1'b0;
  logic [15:0]     opnd_in = '0;
  logic [NSEL-1:0] op_sel = '0;
  logic [15:0]     acc_out;
  logic            acc_neg;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [15:0] m_acc = '0;
  logic [15:0] m_br = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .opnd_load(opnd_load), .opnd_in(opnd_in),
    .op_sel(op_sel), .acc_out(acc_out), .acc_neg(acc_neg)
  );

  function automatic logic [15:0] model_next(logic [15:0] a, logic [15:0] b,
                                             logic [NSEL-1:0] s);
    int hits = 0;
    int which = 0;
    logic [31:0] p;
    for (int i = 0; i < NSEL; i++) if (s[i]) begin hits++; which = i; end
    if (hits != 1) return a;
    p = 32'(a) * 32'(b);
    case (which)
      0: return b;
      1: return 16'((int'(a) + int'(b)) % 65536);
      2: return 16'((int'(a) - int'(b) + 65536) % 65536);
      3: return p[15:0];
      4: return a & b;
      5: return a | b;
      6: return b ^ 16'hFFFF;
      7: return 16'(b / 2);
      default: return 16'((int'(b) * 2) % 65536);
    endcase
  endfunction

  // Reference model advances on the same edges as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0;
      m_br  <= '0;
    end else begin
      m_acc <= model_next(m_acc, m_br, op_sel);
      if (opnd_load) m_br <= opnd_in;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs, then compare at the following falling edge
  task automatic step(bit ld, logic [15:0] d, logic [NSEL-1:0] s, string req);
    opnd_load = ld;
    opnd_in   = d;
    op_sel    = s;
    cur_req   = req;
    @(negedge clk);
    check(req, acc_out, m_acc);
    check("R10", {15'd0, acc_neg}, {15'd0, m_acc[15]});
  endtask

  task automatic put(logic [15:0] d, int idx, string req);
    step(1'b1, d, '0, "R2");
    step(1'b0, 16'h0, NSEL'(1) << idx, req);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", acc_out, 16'h0);
    check("R1", {15'd0, acc_neg}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    put(16'h1234, 0, "R3");                       // load
    check("R3", acc_out, 16'h1234);
    put(16'hFFFF, 1, "R4");                       // add wraps
    check("R4", acc_out, 16'h1233);
    put(16'h2000, 2, "R4");                       // sub wraps below zero
    check("R4", acc_out, 16'hF233);
    check("R10", {15'd0, acc_neg}, 16'h1);
    put(16'h0003, 3, "R5");
    check("R5", acc_out, 16'hD699);
    put(16'h0F0F, 4, "R6");
    check("R6", acc_out, 16'h0609);
    put(16'hF000, 5, "R6");
    check("R6", acc_out, 16'hF609);
    put(16'h00FF, 6, "R7");                       // complement of operand
    check("R7", acc_out, 16'hFF00);
    put(16'h8001, 7, "R8");
    check("R8", acc_out, 16'h4000);
    put(16'h8001, 8, "R8");
    check("R8", acc_out, 16'h0002);
    check("R10", {15'd0, acc_neg}, 16'h0);

    step(1'b0, 16'h0, 9'b000000011, "R9");        // two bits: hold
    check("R9", acc_out, 16'h0002);
    step(1'b0, 16'h0, 9'b000000000, "R9");        // none: hold
    check("R9", acc_out, 16'h0002);
    step(1'b0, 16'hAAAA, 9'b000000001, "R2");     // no capture: old buffer 8001
    check("R2", acc_out, 16'h8001);
    step(1'b1, 16'h5555, 9'b000000001, "R2");     // same-edge capture uses old value
    check("R2", acc_out, 16'h8001);
    step(1'b0, 16'h0, 9'b000000001, "R3");
    check("R3", acc_out, 16'h5555);

    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 120; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(1'b1, lf, NSEL'(1) << (i % NSEL), "R9");
      end
    end

    rst_n = 1'b0;
    #1;
    check("R1", acc_out, 16'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule